// File: doc/BRIEF.md
# Programmable System Clock Prescaler

This block derives a slower bus-domain timing reference from the system clock. A four-bit ratio code selects the divisor. The block does not build a new clock. It drives a clock-enable that bus-side flops qualify their updates with. It also drives a one-cycle flag when a newly requested divisor comes into use.

The code map is not linear. Codes with the top bit clear all mean "no division", and the enable then stays high. The codes with the top bit set climb through powers of two from 2 to 512, and 32 is left out of that ladder. The block samples a new code only at the end of the running division period. Because of this, no enable pulse ever comes early or late because of a code change.

Top module: `sysclk_prescaler`

## Requirements
- R1: While reset is held and right after it is released, the block runs undivided: `clk_en_o` is 1 and `ratio_applied_o` is 0.
- R2: Any code whose bit 3 is 0 (codes 0000 to 0111) selects divide-by-1, and `clk_en_o` is 1 on every cycle.
- R3: Code 1000 gives divide-by-2, 1001 gives divide-by-4, 1010 gives divide-by-8 and 1011 gives divide-by-16.
- R4: Code 1100 gives divide-by-64, 1101 gives divide-by-128, 1110 gives divide-by-256 and 1111 gives divide-by-512. No code gives divide-by-32.
- R5: With a divisor N > 1, `clk_en_o` is high for exactly one cycle in every N cycles, so consecutive pulses are N cycles apart.
- R6: The code is sampled only on the clock edge that closes a cycle in which `clk_en_o` is high. A change in the middle of a period leaves the current period at its full old length, and the new divisor governs the period after it.
- R7: `ratio_applied_o` is high for exactly one cycle: the cycle right after a period-closing edge at which the sampled code selects a different divisor. A new code that selects the same divisor (for example 0000 to 0101) does not raise it.
- R8: A code that is changed and then restored before the period ends is ignored. The period length and `ratio_applied_o` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_code_i | input | 4 | Requested ratio code |
| clk_en_o | output | 1 | Bus-domain clock enable, one pulse per divided period |
| ratio_applied_o | output | 1 | One-cycle pulse when a new divisor takes effect |

## Verification
The hardest case to reach is a code change in the middle of a long period. This is a change that arrives hundreds of cycles before the boundary, or one that is reverted before the boundary arrives. The stimulus lines up on an enable pulse in divide-by-512 mode. It then counts a fixed number of cycles, moves the code, and in the revert case moves it back. It measures the distance to the next pulse and watches the applied flag throughout. A behavioural model runs alongside and is compared on every cycle. The sweep also covers every code, including the same-divisor recodes among the undivided codes.

// File: rtl/sysclk_prescaler_pkg.sv
package sysclk_prescaler_pkg;

  localparam int CODE_W    = 4;
  localparam int MAX_SHIFT = 9;
  localparam int CNT_W     = MAX_SHIFT;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

  typedef logic [SHIFT_W-1:0] shift_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  // Code to log2 of the divisor. Top bit clear selects 1; the ladder skips 2^5.
  function automatic shift_t code_to_shift(input logic [CODE_W-1:0] code);
    shift_t base;
    base = shift_t'(code[1:0]);
    if (!code[CODE_W-1])   return '0;
    else if (!code[2])     return base + shift_t'(1);
    else                   return base + shift_t'(6);
  endfunction

  // Terminal count of a period: divisor minus one.
  function automatic cnt_t shift_to_last(input shift_t s);
    logic [CNT_W:0] one;
    one = {{CNT_W{1'b0}}, 1'b1};
    return cnt_t'((one << s) - one);
  endfunction

endpackage

// File: rtl/prescale_decoder.sv
module prescale_decoder
  import sysclk_prescaler_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output shift_t            shift_o
);
  assign shift_o = code_to_shift(code_i);
endmodule

// File: rtl/prescale_ratio_hold.sv
module prescale_ratio_hold
  import sysclk_prescaler_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   period_end_i,
  input  shift_t req_shift_i,
  output shift_t active_shift_o,
  output logic   applied_o
);
  shift_t active_q;
  logic   applied_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= '0;
      applied_q <= 1'b0;
    end else if (period_end_i) begin
      active_q  <= req_shift_i;
      applied_q <= (req_shift_i != active_q);
    end else begin
      applied_q <= 1'b0;
    end
  end

  assign active_shift_o = active_q;
  assign applied_o      = applied_q;
endmodule

// File: rtl/prescale_period_cnt.sv
module prescale_period_cnt
  import sysclk_prescaler_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t last_i,
  output logic period_end_o,
  output cnt_t cnt_o
);
  cnt_t cnt_q;

  assign period_end_o = (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (period_end_o) cnt_q <= '0;
    else                   cnt_q <= cnt_q + cnt_t'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import sysclk_prescaler_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ratio_code_i,
  output logic              clk_en_o,
  output logic              ratio_applied_o
);
  // Named internal events, visible to the bound checker.
  shift_t req_shift;
  shift_t active_shift;
  cnt_t   period_last;
  cnt_t   period_cnt;
  logic   period_end;

  prescale_decoder u_dec (
    .code_i  (ratio_code_i),
    .shift_o (req_shift)
  );

  prescale_ratio_hold u_hold (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .period_end_i   (period_end),
    .req_shift_i    (req_shift),
    .active_shift_o (active_shift),
    .applied_o      (ratio_applied_o)
  );

  assign period_last = shift_to_last(active_shift);

  prescale_period_cnt u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .last_i       (period_last),
    .period_end_o (period_end),
    .cnt_o        (period_cnt)
  );

  assign clk_en_o = period_end;
endmodule

// File: rtl/sysclk_prescaler_chk.sv
module sysclk_prescaler_chk
  import sysclk_prescaler_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   clk_en_o,
  input logic   ratio_applied_o,
  input shift_t req_shift,
  input shift_t active_shift
);
  logic [CNT_W:0] gap_q;
  logic           seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (clk_en_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R2: undivided operation keeps the enable high
  a_r2_undiv_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_shift == '0) |-> clk_en_o);

  // R5: a divided enable lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |=> (active_shift == '0 || !clk_en_o));

  // R5: pulse spacing equals the divisor that governed the period
  a_r5_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && seen_q) |-> (32'(gap_q) == (32'd1 << active_shift) - 32'd1));

  // R6: the divisor never moves inside a period
  a_r6_hold_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |=> $stable(active_shift));

  // R7: a differing request at a boundary is flagged
  a_r7_flag_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && req_shift != active_shift) |=> ratio_applied_o);

  // R7: the flag appears only right after a boundary that changed the divisor
  a_r7_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_applied_o |-> ($past(clk_en_o) && active_shift != $past(active_shift)));

  // R7: the flag is a single-cycle pulse
  a_r7_flag_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_applied_o |=> !ratio_applied_o);
endmodule

bind sysclk_prescaler sysclk_prescaler_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .clk_en_o        (clk_en_o),
  .ratio_applied_o (ratio_applied_o),
  .req_shift       (req_shift),
  .active_shift    (active_shift)
);

// File: tb/sysclk_prescaler_bench.sv
`timescale 1ns/1ps
module sysclk_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] code = 4'd0;
  logic       en, applied;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sysclk_prescaler u_sysclk_prescaler (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .ratio_code_i    (code),
    .clk_en_o        (en),
    .ratio_applied_o (applied)
  );

  // Divisor restated from the requirement tables.
  function automatic int ref_div(input logic [3:0] c);
    case (c)
      4'b1000: return 2;
      4'b1001: return 4;
      4'b1010: return 8;
      4'b1011: return 16;
      4'b1100: return 64;
      4'b1101: return 128;
      4'b1110: return 256;
      4'b1111: return 512;
      default: return 1;
    endcase
  endfunction

  // Behavioural reference model.
  int m_div = 1, m_pos = 0;
  bit m_app = 0;
  wire m_en = (m_pos == m_div - 1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div <= 1; m_pos <= 0; m_app <= 0;
    end else if (m_en) begin
      m_app <= (ref_div(code) != m_div);
      m_div <= ref_div(code);
      m_pos <= 0;
    end else begin
      m_pos <= m_pos + 1;
      m_app <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (en !== m_en) begin
        fails++;
        $display("FAIL %s enable: got %0b expected %0b", (m_div == 1) ? "R2" : "R5", en, m_en);
      end
      tests++;
      if (applied !== m_app) begin
        fails++;
        $display("FAIL R7 applied flag: got %0b expected %0b", applied, m_app);
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_en();
    do @(negedge clk); while (!en);
  endtask

  task automatic measure(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!en);
  endtask

  task automatic settle(input logic [3:0] c);
    int g;
    code = c;
    wait_en(); wait_en();
    measure(g);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int g, napp;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 en in reset", int'(en), 1);
    check("R1 applied in reset", int'(applied), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 en after reset", int'(en), 1);
    check("R1 applied after reset", int'(applied), 0);

    // R2 / R3 / R4: sweep every code
    for (int c = 0; c < 16; c++) begin
      code = 4'(c);
      wait_en(); wait_en();
      measure(g);
      if (c < 8)       check("R2 undivided period", g, 1);
      else if (c < 12) check("R3 low ladder period", g, ref_div(4'(c)));
      else             check("R4 high ladder period", g, ref_div(4'(c)));
      check("R4 never 32", int'(g == 32), 0);
    end

    // R6: mid-period change keeps the old period length
    settle(4'b1111);
    wait_en();
    g = 0;
    repeat (100) begin @(negedge clk); g++; end
    code = 4'b1000;
    do begin @(negedge clk); g++; end while (!en);
    check("R6 old period kept", g, 512);
    measure(g);
    check("R6 new period follows", g, 2);

    // R8: change reverted before boundary is ignored
    settle(4'b1111);
    wait_en();
    g = 0; napp = 0;
    repeat (50) begin @(negedge clk); g++; napp += int'(applied); end
    code = 4'b1000;
    repeat (50) begin @(negedge clk); g++; napp += int'(applied); end
    code = 4'b1111;
    do begin @(negedge clk); g++; napp += int'(applied); end while (!en);
    check("R8 period unchanged", g, 512);
    measure(g);
    napp += int'(applied);
    check("R8 next period unchanged", g, 512);
    check("R8 no applied flag", napp, 0);

    // R7: same-divisor recode raises no flag
    settle(4'b0000);
    code = 4'b0101;
    napp = 0;
    repeat (8) begin @(negedge clk); napp += int'(applied); end
    check("R7 same divisor no flag", napp, 0);

    // R7: real change raises exactly one pulse
    code = 4'b1001;
    napp = 0;
    repeat (12) begin @(negedge clk); napp += int'(applied); end
    check("R7 single applied pulse", napp, 1);
    measure(g);
    check("R7 new divisor in use", g, 4);

    summary();
  end
endmodule